// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a host processor 24 general-purpose port pins, arranged as three 8-bit ports called A, B and C. The host reaches it through an 8-bit data bus with two address bits, an active-low chip select and active-low read and write strobes. The read data and write data travel on separate buses. Each port pin appears as an input, an output value and an output enable, so the pads themselves stay outside the block.

The pins fall into two groups of twelve. Group A is port A together with the upper half of port C. Group B is port B together with the lower half of port C. A control write puts each group into one of these modes:
- plain latched input or output;
- strobed transfer in one direction, where some port C pins carry the strobe, acknowledge, buffer-full and interrupt lines;
- for group A only, a strobed bidirectional bus.

A second kind of control write sets or clears a single port C bit. The same write also controls the interrupt enables of the strobed modes. The host can read the control word back at any time.

All host strobes and port C handshake inputs are taken as signals synchronous to `clk`. They are edge-detected inside the block, so each edge takes effect on the clock after it is first sampled.

Top module: `pario_ctrl`

## Requirements
- R1: After reset, the control register reads 0x9B. Every output enable is 0 and every output latch is 0.
- R2: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register. A write to address 3 with bit 7 set stores the whole byte as the new mode word, and a read of address 3 returns that byte.
- R3: While chip select is high, writes have no effect and the read data bus is 0.
- R4: The mode word is decoded as follows.
  - Bits 6:5 give the group A mode: 00 is plain, 01 is strobed and 1x is bidirectional.
  - Bit 2 gives the group B mode: 0 is plain and 1 is strobed.
  - A direction bit of 1 makes its pins inputs. Bit 4 is the direction of port A, bit 3 of the port C upper half, bit 1 of port B and bit 0 of the port C lower half.
  - A port whose pins are outputs drives its output latch.
- R5: A mode write clears all three output latches, every handshake flag and every interrupt enable.
- R6: A control write with bit 7 clear changes only port C bit number wdata[3:1], and sets it to wdata[0].
- R7: In plain mode, a read of an input port returns the pin value as sampled on the previous clock. A read of an output port returns its output latch.
- R8: This requirement covers group A in strobed input mode.
  - A falling edge on pc_in[4] latches port A into the input latch and drives the buffer-full flag high on pc_out[5].
  - Later changes on port A are not seen until the next such edge.
  - When a host read of port A completes, the flag clears.
- R9: In strobed input mode, group A raises its interrupt on pc_out[3] when pc_in[4] returns high, but only if the enable was set beforehand by writing port C bit 4 to 1. The interrupt clears when a host read of port A completes.
- R10: This requirement covers group A in strobed output mode.
  - A host write of port A drives the active-low buffer-full line pc_out[7] low.
  - A falling edge on the acknowledge pin pc_in[6] drives pc_out[7] high again.
  - The rising edge of the acknowledge raises pc_out[3], if enabled by writing port C bit 6 to 1.
  - The next host write of port A clears pc_out[3].
- R11: In strobed mode, group B uses three port C pins. pc_in[2] is its strobe or acknowledge. pc_out[1] is its buffer-full line: active high for input, active low for output. pc_out[0] is its interrupt, which is enabled through port C bit 2.
- R12: In bidirectional mode, port A is driven only while the acknowledge pc_in[6] is low. In this mode both the input and the output handshakes of R8 to R10 work on the same port.
- R13: The output enables of port C depend on the mode.
  - Port C pins used as handshake inputs are never driven.
  - Handshake outputs are always driven.
  - All other port C pins follow their half's direction bit.
  - A read of port C returns the driven value on output pins and the sampled pin value on input pins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, 0 when no read is active |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin values, including handshake inputs |
| pc_out | output | 8 | Port C output values, including handshake outputs |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The hardest state to reach from the ports is a raised interrupt. It needs three things in order: the right mode word, an enable written through a single-bit port C write, and a full strobe or acknowledge cycle on a port C input pin. Only after that does the host read or write that clears it. The bench drives each such sequence step by step at falling clock edges and samples the handshake pins between steps. It also repeats a strobe after a fresh mode write, which shows that the enable was cleared. Bidirectional mode is reached by toggling the acknowledge pin around a host write, so that the port A output enable can be seen turning on and off.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int PW = 8;
  localparam int AW = 2;
  localparam logic [PW-1:0] CTRL_RESET = 8'h9B;

  localparam logic [AW-1:0] SEL_A    = 2'd0;
  localparam logic [AW-1:0] SEL_B    = 2'd1;
  localparam logic [AW-1:0] SEL_C    = 2'd2;
  localparam logic [AW-1:0] SEL_CTRL = 2'd3;

  // Port C handshake positions (decoded by neighbouring logic and software)
  localparam int PCA_INTR = 3;
  localparam int PCA_STB  = 4;
  localparam int PCA_IBF  = 5;
  localparam int PCA_ACK  = 6;
  localparam int PCA_OBF  = 7;
  localparam int PCB_INTR = 0;
  localparam int PCB_BUF  = 1;
  localparam int PCB_HSI  = 2;

  typedef enum logic [1:0] {
    GM_SIMPLE  = 2'd0,
    GM_STROBED = 2'd1,
    GM_BIDIR   = 2'd2
  } grp_mode_e;

  typedef struct packed {
    grp_mode_e a_mode;
    logic      a_in;
    logic      cu_in;
    logic      b_strobed;
    logic      b_in;
    logic      cl_in;
  } pio_cfg_t;

  function automatic pio_cfg_t decode_ctrl(input logic [PW-1:0] w);
    pio_cfg_t c;
    c.a_mode    = w[6] ? GM_BIDIR : (w[5] ? GM_STROBED : GM_SIMPLE);
    c.a_in      = w[4];
    c.cu_in     = w[3];
    c.b_strobed = w[2];
    c.b_in      = w[1];
    c.cl_in     = w[0];
    return c;
  endfunction

  function automatic logic a_in_side(input pio_cfg_t c);
    return (c.a_mode == GM_BIDIR) || (c.a_mode == GM_STROBED && c.a_in);
  endfunction

  function automatic logic a_out_side(input pio_cfg_t c);
    return (c.a_mode == GM_BIDIR) || (c.a_mode == GM_STROBED && !c.a_in);
  endfunction

  // One-hot {b, a_out, a_in}: which interrupt enable a bit write reaches
  function automatic logic [2:0] inte_target(input pio_cfg_t c, input logic [2:0] idx);
    logic [2:0] t;
    t = 3'b000;
    if (idx == 3'(PCA_STB) && a_in_side(c))  t[0] = 1'b1;
    if (idx == 3'(PCA_ACK) && a_out_side(c)) t[1] = 1'b1;
    if (idx == 3'(PCB_HSI) && c.b_strobed)   t[2] = 1'b1;
    return t;
  endfunction
endpackage

// File: rtl/pio_bus_if.sv
module pio_bus_if #(
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  output logic          wr_ev,
  output logic          rd_end_ev,
  output logic [AW-1:0] rd_end_addr,
  output logic          rd_live
);
  logic wr_act, rd_act, wr_q, rd_q;
  logic [AW-1:0] rd_addr_q;

  assign wr_act = !cs_n && !wr_n;
  assign rd_act = !cs_n && !rd_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      if (rd_act) rd_addr_q <= addr;
    end
  end

  assign wr_ev       = wr_act && !wr_q;
  assign rd_end_ev   = rd_q && !rd_act;
  assign rd_end_addr = rd_addr_q;
  assign rd_live     = rd_act;
endmodule

// File: rtl/pio_hs_chan.sv
module pio_hs_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         follow,
  input  logic         in_en,
  input  logic         out_en,
  input  logic         stb_n,
  input  logic         ack_n,
  input  logic [W-1:0] port_in,
  input  logic         rd_ev,
  input  logic         wr_ev,
  input  logic         inte_in,
  input  logic         inte_out,
  output logic [W-1:0] in_lat,
  output logic         ibf,
  output logic         obf,
  output logic         intr,
  output logic         stb_fall
);
  logic stb_q, ack_q, pend_in, pend_out;
  logic stb_rise, ack_fall, ack_rise;

  assign stb_fall = in_en  && stb_q  && !stb_n;
  assign stb_rise = in_en  && !stb_q && stb_n;
  assign ack_fall = out_en && ack_q  && !ack_n;
  assign ack_rise = out_en && !ack_q && ack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q    <= 1'b1;
      ack_q    <= 1'b1;
      ibf      <= 1'b0;
      obf      <= 1'b0;
      pend_in  <= 1'b0;
      pend_out <= 1'b0;
      in_lat   <= '0;
    end else begin
      stb_q <= stb_n;
      ack_q <= ack_n;
      if (follow || stb_fall) in_lat <= port_in;
      if (clr) begin
        ibf      <= 1'b0;
        obf      <= 1'b0;
        pend_in  <= 1'b0;
        pend_out <= 1'b0;
      end else begin
        if (stb_fall)   ibf <= 1'b1;
        else if (rd_ev) ibf <= 1'b0;

        if (rd_ev)                             pend_in <= 1'b0;
        else if (stb_rise && ibf && inte_in)   pend_in <= 1'b1;

        if (wr_ev && out_en) obf <= 1'b1;
        else if (ack_fall)   obf <= 1'b0;

        if (wr_ev)                     pend_out <= 1'b0;
        else if (ack_rise && inte_out) pend_out <= 1'b1;
      end
    end
  end

  assign intr = pend_in || pend_out;
endmodule

// File: rtl/pio_portc_map.sv
module pio_portc_map
  import pio_pkg::*;
(
  input  pio_cfg_t      cfg,
  input  logic [PW-1:0] pc_lat,
  input  logic [PW-1:0] pc_in_q,
  input  logic          ibf_a,
  input  logic          obf_a,
  input  logic          intr_a,
  input  logic          ibf_b,
  input  logic          obf_b,
  input  logic          intr_b,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe,
  output logic [PW-1:0] pc_rd
);
  localparam int HW = PW / 2;

  always_comb begin
    pc_out = pc_lat;
    pc_oe  = {{HW{!cfg.cu_in}}, {HW{!cfg.cl_in}}};
    if (cfg.a_mode != GM_SIMPLE) begin
      pc_out[PCA_INTR] = intr_a;
      pc_oe[PCA_INTR]  = 1'b1;
      if (a_in_side(cfg)) begin
        pc_oe[PCA_STB]  = 1'b0;
        pc_out[PCA_IBF] = ibf_a;
        pc_oe[PCA_IBF]  = 1'b1;
      end
      if (a_out_side(cfg)) begin
        pc_oe[PCA_ACK]  = 1'b0;
        pc_out[PCA_OBF] = !obf_a;
        pc_oe[PCA_OBF]  = 1'b1;
      end
    end
    if (cfg.b_strobed) begin
      pc_oe[PCB_HSI]   = 1'b0;
      pc_out[PCB_BUF]  = cfg.b_in ? ibf_b : !obf_b;
      pc_oe[PCB_BUF]   = 1'b1;
      pc_out[PCB_INTR] = intr_b;
      pc_oe[PCB_INTR]  = 1'b1;
    end
  end

  assign pc_rd = (pc_oe & pc_out) | (~pc_oe & pc_in_q);
endmodule

// File: rtl/pario_ctrl.sv
module pario_ctrl
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [PW-1:0] wdata,
  output logic [PW-1:0] rdata,
  input  logic [PW-1:0] pa_in,
  output logic [PW-1:0] pa_out,
  output logic          pa_oe,
  input  logic [PW-1:0] pb_in,
  output logic [PW-1:0] pb_out,
  output logic          pb_oe,
  input  logic [PW-1:0] pc_in,
  output logic [PW-1:0] pc_out,
  output logic [PW-1:0] pc_oe
);
  logic [PW-1:0] ctrl_q, pa_lat, pb_lat, pc_lat, pc_in_q, pc_rd;
  logic [PW-1:0] a_in_lat, b_in_lat;
  logic inte_a_in, inte_a_out, inte_b;
  logic wr_ev, rd_end_ev, rd_live;
  logic [AW-1:0] rd_end_addr;
  pio_cfg_t cfg;

  // named internal events
  logic ctl_wr, mode_set_ev, bsr_ev, rd_ev_a, rd_ev_b, wr_ev_a, wr_ev_b;
  logic a_in_side_w, a_out_side_w, a_bidir;
  logic ibf_a, obf_a, intr_a, stb_fall_a;
  logic ibf_b, obf_b, intr_b, stb_fall_b;
  logic [2:0] bsr_idx, inte_hit;
  logic bsr_val;

  pio_bus_if #(.AW(AW)) bus_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .wr_ev(wr_ev), .rd_end_ev(rd_end_ev), .rd_end_addr(rd_end_addr), .rd_live(rd_live)
  );

  assign cfg          = decode_ctrl(ctrl_q);
  assign a_in_side_w  = a_in_side(cfg);
  assign a_out_side_w = a_out_side(cfg);
  assign a_bidir      = (cfg.a_mode == GM_BIDIR);

  assign ctl_wr      = wr_ev && (addr == SEL_CTRL);
  assign mode_set_ev = ctl_wr && wdata[PW-1];
  assign bsr_ev      = ctl_wr && !wdata[PW-1];
  assign bsr_idx     = wdata[3:1];
  assign bsr_val     = wdata[0];
  assign inte_hit    = inte_target(cfg, bsr_idx);
  assign wr_ev_a     = wr_ev && (addr == SEL_A);
  assign wr_ev_b     = wr_ev && (addr == SEL_B);
  assign rd_ev_a     = rd_end_ev && (rd_end_addr == SEL_A);
  assign rd_ev_b     = rd_end_ev && (rd_end_addr == SEL_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= CTRL_RESET;
      pa_lat     <= '0;
      pb_lat     <= '0;
      pc_lat     <= '0;
      pc_in_q    <= '0;
      inte_a_in  <= 1'b0;
      inte_a_out <= 1'b0;
      inte_b     <= 1'b0;
    end else begin
      pc_in_q <= pc_in;
      if (mode_set_ev) begin
        ctrl_q     <= wdata;
        pa_lat     <= '0;
        pb_lat     <= '0;
        pc_lat     <= '0;
        inte_a_in  <= 1'b0;
        inte_a_out <= 1'b0;
        inte_b     <= 1'b0;
      end else begin
        if (wr_ev_a) pa_lat <= wdata;
        if (wr_ev_b) pb_lat <= wdata;
        if (wr_ev && addr == SEL_C) pc_lat <= wdata;
        if (bsr_ev) begin
          pc_lat[bsr_idx] <= bsr_val;
          if (inte_hit[0]) inte_a_in  <= bsr_val;
          if (inte_hit[1]) inte_a_out <= bsr_val;
          if (inte_hit[2]) inte_b     <= bsr_val;
        end
      end
    end
  end

  pio_hs_chan #(.W(PW)) chan_a_i (
    .clk(clk), .rst_n(rst_n), .clr(mode_set_ev),
    .follow(cfg.a_mode == GM_SIMPLE && cfg.a_in),
    .in_en(a_in_side_w), .out_en(a_out_side_w),
    .stb_n(pc_in[PCA_STB]), .ack_n(pc_in[PCA_ACK]), .port_in(pa_in),
    .rd_ev(rd_ev_a), .wr_ev(wr_ev_a), .inte_in(inte_a_in), .inte_out(inte_a_out),
    .in_lat(a_in_lat), .ibf(ibf_a), .obf(obf_a), .intr(intr_a), .stb_fall(stb_fall_a)
  );

  pio_hs_chan #(.W(PW)) chan_b_i (
    .clk(clk), .rst_n(rst_n), .clr(mode_set_ev),
    .follow(!cfg.b_strobed && cfg.b_in),
    .in_en(cfg.b_strobed && cfg.b_in), .out_en(cfg.b_strobed && !cfg.b_in),
    .stb_n(pc_in[PCB_HSI]), .ack_n(pc_in[PCB_HSI]), .port_in(pb_in),
    .rd_ev(rd_ev_b), .wr_ev(wr_ev_b), .inte_in(inte_b), .inte_out(inte_b),
    .in_lat(b_in_lat), .ibf(ibf_b), .obf(obf_b), .intr(intr_b), .stb_fall(stb_fall_b)
  );

  pio_portc_map portc_i (
    .cfg(cfg), .pc_lat(pc_lat), .pc_in_q(pc_in_q),
    .ibf_a(ibf_a), .obf_a(obf_a), .intr_a(intr_a),
    .ibf_b(ibf_b), .obf_b(obf_b), .intr_b(intr_b),
    .pc_out(pc_out), .pc_oe(pc_oe), .pc_rd(pc_rd)
  );

  assign pa_out = pa_lat;
  assign pb_out = pb_lat;
  assign pa_oe  = a_bidir ? !pc_in[PCA_ACK] : !cfg.a_in;
  assign pb_oe  = !cfg.b_in;

  always_comb begin
    rdata = '0;
    if (rd_live) begin
      case (addr)
        SEL_A:   rdata = (cfg.a_in || a_bidir) ? a_in_lat : pa_lat;
        SEL_B:   rdata = cfg.b_in ? b_in_lat : pb_lat;
        SEL_C:   rdata = pc_rd;
        default: rdata = ctrl_q;
      endcase
    end
  end
endmodule

// File: rtl/pario_ctrl_chk.sv
module pario_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_set_ev,
  input logic       bsr_ev,
  input logic [7:0] wdata,
  input logic [7:0] ctrl_q,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_lat,
  input logic [7:0] pc_oe,
  input logic       ibf_a,
  input logic       ibf_b,
  input logic       stb_fall_a,
  input logic       stb_fall_b,
  input logic       rd_ev_a,
  input logic       intr_a,
  input logic       inte_a_in,
  input logic       inte_a_out,
  input logic       a_in_side_w
);
  assert_ctrl_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set_ev |=> ctrl_q == $past(wdata));

  assert_latch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_set_ev |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_lat == 8'h00));

  assert_bit_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bsr_ev |=> pc_lat[$past(wdata[3:1])] == $past(wdata[0]));

  assert_ibf_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf_a) |-> $past(stb_fall_a));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev_a && !stb_fall_a) |=> !ibf_a);

  assert_intr_enabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_a) |-> $past(inte_a_in || inte_a_out));

  assert_ibf_b_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf_b) |-> $past(stb_fall_b));

  assert_strobe_undriven_R13: assert property (@(posedge clk) disable iff (!rst_n)
    a_in_side_w |-> !pc_oe[4]);
endmodule

bind pario_ctrl pario_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_set_ev(mode_set_ev), .bsr_ev(bsr_ev),
  .wdata(wdata), .ctrl_q(ctrl_q), .pa_out(pa_out), .pb_out(pb_out),
  .pc_lat(pc_lat), .pc_oe(pc_oe), .ibf_a(ibf_a), .ibf_b(ibf_b),
  .stb_fall_a(stb_fall_a), .stb_fall_b(stb_fall_b), .rd_ev_a(rd_ev_a),
  .intr_a(intr_a), .inte_a_in(inte_a_in), .inte_a_out(inte_a_out),
  .a_in_side_w(a_in_side_w)
);

// File: tb/pario_ctrl_tb_top.sv
module pario_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, pa_out, pb_out, pc_out, pc_oe;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic pa_oe, pb_oe;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  localparam int OBS_RD = 0, OBS_PA = 1, OBS_PAOE = 2, OBS_PB = 3,
                 OBS_PBOE = 4, OBS_PC = 5, OBS_PCOE = 6;

  typedef struct {
    int         src;
    logic [7:0] exp;
    logic [7:0] mask;
    string      req;
  } exp_t;
  exp_t sb_q[$];
  event sample_ev;

  always #10 clk = ~clk;

  pario_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  function automatic logic [7:0] obs(input int s);
    case (s)
      OBS_RD:   return rdata;
      OBS_PA:   return pa_out;
      OBS_PAOE: return {7'b0, pa_oe};
      OBS_PB:   return pb_out;
      OBS_PBOE: return {7'b0, pb_oe};
      OBS_PC:   return pc_out;
      default:  return pc_oe;
    endcase
  endfunction

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(sample_ev);
      while (sb_q.size() > 0) begin
        exp_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = obs(it.src);
        n_checks++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          n_errors++;
          $display("FAIL %s: source %0d actual %02h expected %02h (mask %02h)",
                   it.req, it.src, act & it.mask, it.exp & it.mask, it.mask);
        end
      end
    end
  end

  task automatic expect_obs(input int s, input logic [7:0] e, input logic [7:0] m, input string req);
    exp_t it;
    #1;
    it.src = s; it.exp = e; it.mask = m; it.req = req;
    sb_q.push_back(it);
    ->sample_ev;
    wait (sb_q.size() == 0);
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic host_rd(input logic [1:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    addr = a; cs_n = 1'b0; rd_n = 1'b0;
    expect_obs(OBS_RD, e, 8'hFF, req);
    @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic set_pc(input logic [7:0] v);
    @(negedge clk);
    pc_in = v;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    host_rd(2'd3, 8'h9B, "R1 ctrl reset");
    expect_obs(OBS_PAOE, 8'h00, 8'hFF, "R1 pa_oe");
    expect_obs(OBS_PBOE, 8'h00, 8'hFF, "R1 pb_oe");
    expect_obs(OBS_PCOE, 8'h00, 8'hFF, "R1 pc_oe");
    expect_obs(OBS_PA,   8'h00, 8'hFF, "R1 pa_out");

    // R2 / R4 plain mode, all outputs
    host_wr(2'd3, 8'h80);
    host_rd(2'd3, 8'h80, "R2 ctrl readback");
    expect_obs(OBS_PAOE, 8'h01, 8'hFF, "R4 pa_oe out");
    expect_obs(OBS_PCOE, 8'hFF, 8'hFF, "R4 pc_oe out");
    host_wr(2'd0, 8'h5A);
    host_wr(2'd1, 8'hC3);
    host_wr(2'd2, 8'h0F);
    expect_obs(OBS_PA, 8'h5A, 8'hFF, "R2 port A write");
    expect_obs(OBS_PB, 8'hC3, 8'hFF, "R2 port B write");
    expect_obs(OBS_PC, 8'h0F, 8'hFF, "R2 port C write");
    host_rd(2'd0, 8'h5A, "R7 output port reads latch");

    // R3 chip select gating
    @(negedge clk);
    addr = 2'd0; wdata = 8'hFF; cs_n = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    expect_obs(OBS_PA, 8'h5A, 8'hFF, "R3 write ignored");
    rd_n = 1'b0;
    expect_obs(OBS_RD, 8'h00, 8'hFF, "R3 rdata idle");
    @(negedge clk);
    rd_n = 1'b1;

    // R6 single-bit writes
    host_wr(2'd3, 8'h0B);
    expect_obs(OBS_PC, 8'h2F, 8'hFF, "R6 set bit 5");
    host_wr(2'd3, 8'h00);
    expect_obs(OBS_PC, 8'h2E, 8'hFF, "R6 clear bit 0");

    // R5 mode write clears latches
    host_wr(2'd3, 8'h80);
    expect_obs(OBS_PA, 8'h00, 8'hFF, "R5 pa cleared");
    expect_obs(OBS_PB, 8'h00, 8'hFF, "R5 pb cleared");
    expect_obs(OBS_PC, 8'h00, 8'hFF, "R5 pc cleared");

    // R4 / R7 / R13 mixed plain mode
    host_wr(2'd3, 8'h91);
    expect_obs(OBS_PAOE, 8'h00, 8'hFF, "R4 pa input");
    expect_obs(OBS_PCOE, 8'hF0, 8'hFF, "R4 pc halves");
    pa_in = 8'h3C;
    pc_in = 8'hA5;
    host_rd(2'd0, 8'h3C, "R7 input port");
    host_rd(2'd2, 8'h05, "R13 port C mixed read");
    pc_in = 8'hFF;

    // R8 / R9 strobed input on group A
    host_wr(2'd3, 8'hB0);
    expect_obs(OBS_PCOE, 8'hEF, 8'hFF, "R13 strobed input pc_oe");
    pa_in = 8'h77;
    set_pc(8'hEF);
    expect_obs(OBS_PC, 8'h20, 8'h20, "R8 ibf set");
    pa_in = 8'h11;
    set_pc(8'hFF);
    expect_obs(OBS_PC, 8'h00, 8'h08, "R9 no intr when disabled");
    host_rd(2'd0, 8'h77, "R8 latched value");
    expect_obs(OBS_PC, 8'h00, 8'h20, "R8 ibf cleared by read");
    host_wr(2'd3, 8'h09);
    pa_in = 8'h22;
    set_pc(8'hEF);
    set_pc(8'hFF);
    expect_obs(OBS_PC, 8'h08, 8'h08, "R9 intr raised");
    host_rd(2'd0, 8'h22, "R9 read data");
    expect_obs(OBS_PC, 8'h00, 8'h28, "R9 intr and ibf cleared");

    // R10 strobed output on group A
    host_wr(2'd3, 8'hA0);
    expect_obs(OBS_PCOE, 8'hBF, 8'hFF, "R13 strobed output pc_oe");
    expect_obs(OBS_PC, 8'h80, 8'h80, "R10 obf idle high");
    host_wr(2'd3, 8'h0D);
    host_wr(2'd0, 8'h99);
    expect_obs(OBS_PA, 8'h99, 8'hFF, "R10 data driven");
    expect_obs(OBS_PAOE, 8'h01, 8'hFF, "R10 pa_oe");
    expect_obs(OBS_PC, 8'h00, 8'h80, "R10 obf low");
    set_pc(8'hBF);
    expect_obs(OBS_PC, 8'h80, 8'h80, "R10 ack releases obf");
    set_pc(8'hFF);
    expect_obs(OBS_PC, 8'h08, 8'h08, "R10 intr on ack rise");
    host_wr(2'd0, 8'h12);
    expect_obs(OBS_PC, 8'h00, 8'h88, "R10 write clears intr");

    // R11 group B strobed input
    host_wr(2'd3, 8'h86);
    expect_obs(OBS_PCOE, 8'hFB, 8'hFF, "R11 pc_oe");
    host_wr(2'd3, 8'h05);
    pb_in = 8'h6E;
    set_pc(8'hFB);
    expect_obs(OBS_PC, 8'h02, 8'h02, "R11 ibf b");
    set_pc(8'hFF);
    expect_obs(OBS_PC, 8'h01, 8'h01, "R11 intr b");
    host_rd(2'd1, 8'h6E, "R11 latched b");
    expect_obs(OBS_PC, 8'h00, 8'h03, "R11 flags cleared");

    // R12 bidirectional
    host_wr(2'd3, 8'hC0);
    expect_obs(OBS_PAOE, 8'h00, 8'hFF, "R12 released while ack high");
    expect_obs(OBS_PCOE, 8'hAF, 8'hFF, "R13 bidir pc_oe");
    host_wr(2'd0, 8'h44);
    expect_obs(OBS_PC, 8'h00, 8'h80, "R12 obf low");
    set_pc(8'hBF);
    expect_obs(OBS_PAOE, 8'h01, 8'hFF, "R12 driven while ack low");
    expect_obs(OBS_PA, 8'h44, 8'hFF, "R12 data");
    expect_obs(OBS_PC, 8'h80, 8'h80, "R12 obf released");
    set_pc(8'hFF);
    expect_obs(OBS_PAOE, 8'h00, 8'hFF, "R12 released after ack");
    pa_in = 8'h3D;
    set_pc(8'hEF);
    expect_obs(OBS_PC, 8'h20, 8'h20, "R12 ibf");
    set_pc(8'hFF);
    host_rd(2'd0, 8'h3D, "R12 input data");

    // R5 enables cleared by mode write
    host_wr(2'd3, 8'h09);
    host_wr(2'd3, 8'hB0);
    set_pc(8'hEF);
    set_pc(8'hFF);
    expect_obs(OBS_PC, 8'h00, 8'h08, "R5 enable cleared");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule